// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Generator

This block produces the modulation word for a spread-spectrum clock. It runs on the reference clock and gives out a signed frequency offset. A fractional-N or DCO stage downstream adds that offset to the nominal frequency of the output clock. The offset follows a triangle. It starts at its lowest value, climbs to its highest value at mid-period, and falls back to the start value by the end of each modulation period.

Five inputs each carry a three-level setting (low, middle or high) as a 2-bit code. The range select sets the length of the modulation period in reference cycles. The two spread selects together pick center spread, down spread or no spread, and one of four deviation steps. A 2-bit sub-band index trims the deviation, which gets smaller as the input sub-band rises. All settings are latched only at a period boundary. This keeps every sweep whole.

The active-low power-down input holds the sweep where it is and forces the offset to zero. The sweep resumes from the held phase when power-down is released.

Top module: `ssc_profile_gen`

## Requirements
- R1: Each three-level input is coded as 2'b00 = low, 2'b01 = middle, 2'b10 = high. The code 2'b11 is treated as middle.
- R2: The modulation period is 2^DR_LOG2_LO cycles (default 128) for range low, 2^DR_LOG2_HI cycles (default 256) for range high, and 2^DR_LOG2_MID cycles (default 512) for range middle.
- R3: The spread pair (spread_a_i, spread_b_i) selects the mode and step as follows. Center spread: (low,low) = step 0, (low,mid) = step 1, (low,high) = step 2, (mid,low) = step 3. Down spread: (high,high) = step 0, (high,low) = step 1, (mid,high) = step 2, (high,mid) = step 3. The pair (mid,mid) selects no spread.
- R4: The center magnitude M, in units of 0.1 %, is the step base minus subband_i, with a floor of 1. The step bases are 14, 12, 6 and 5 for steps 0 to 3. Center spread swings from -M to +M. Down spread swings from -2M to 0.
- R5: offset_o is a signed fixed-point value with FRAC_W fractional bits, in units of 0.1 %. Let P be the phase (0 to DR-1) and H = DR/2. Let T = P for P < H, and T = DR - P otherwise. Then offset_o = min + floor(2·M·T·2^FRAC_W / H), where min is -M·2^FRAC_W (center) or -2M·2^FRAC_W (down).
- R6: Inputs are latched at two moments only: on the first clock after reset, and on the clock that moves the phase from DR-1 to 0. Changes at any other time have no effect until the next boundary.
- R7: While pd_ni is low, the phase is held and offset_o is 0 from the next clock on. When pd_ni rises, the sweep continues from the held phase.
- R8: While rst_ni is low, offset_o is 0. On the first clock after release, the inputs are latched and the phase starts at 0.
- R9: With no spread selected, offset_o stays 0 through the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_ni | input | 1 | Power-down, active low |
| range_sel_i | input | 2 | Three-level range select (sets the period) |
| spread_a_i | input | 2 | Three-level spread select, first of the pair |
| spread_b_i | input | 2 | Three-level spread select, second of the pair |
| subband_i | input | 2 | Input sub-band index, 0 to 3 |
| offset_o | output | OFF_W | Signed frequency offset, 0.1 % units with FRAC_W fraction bits |

## Verification
The assertions assume that every input is synchronous to clk_i and changes only between rising edges. They also assume that the DR_LOG2 parameters are at least 2, so that a half period exists. The bench changes inputs only on falling edges and holds them for whole cycles. It writes every 2-bit code, including 2'b11, so that no setting is undefined. Configuration changes are placed in the middle of a period, so that the latching at the boundary can be observed at offset_o.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  localparam int LOG_W = 4;
  localparam int MAG_W = 5;

  localparam logic [1:0] LVL_LO  = 2'b00;
  localparam logic [1:0] LVL_MID = 2'b01;
  localparam logic [1:0] LVL_HI  = 2'b10;

  typedef enum logic [1:0] {MODE_NONE = 2'd0, MODE_CENTER = 2'd1, MODE_DOWN = 2'd2} mode_e;

  typedef struct packed {
    mode_e            mode;
    logic [MAG_W-1:0] mag;
    logic [LOG_W-1:0] lg;
  } cfg_t;
endpackage

// File: rtl/ssc_tri_level_decode.sv
module ssc_tri_level_decode #(
  parameter int N = 3
) (
  input  logic [2*N-1:0] raw_i,
  output logic [2*N-1:0] lvl_o
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    // illegal code folds to the floating (middle) level
    assign lvl_o[2*g +: 2] = (raw_i[2*g +: 2] == 2'b11) ? ssc_pkg::LVL_MID : raw_i[2*g +: 2];
  end
endmodule

// File: rtl/ssc_spread_lut.sv
module ssc_spread_lut
  import ssc_pkg::*;
#(
  parameter int STEP0_MAG = 14,
  parameter int STEP1_MAG = 12,
  parameter int STEP2_MAG = 6,
  parameter int STEP3_MAG = 5
) (
  input  logic [1:0]       sel_a_i,
  input  logic [1:0]       sel_b_i,
  input  logic [1:0]       subband_i,
  output mode_e            mode_o,
  output logic [MAG_W-1:0] mag_o
);
  localparam int MAG_TAB [4] = '{STEP0_MAG, STEP1_MAG, STEP2_MAG, STEP3_MAG};

  logic [1:0] step;
  int         mag_v;

  always_comb begin
    mode_o = MODE_NONE;
    step   = 2'd0;
    unique case ({sel_a_i, sel_b_i})
      {LVL_LO,  LVL_LO }: begin mode_o = MODE_CENTER; step = 2'd0; end
      {LVL_LO,  LVL_MID}: begin mode_o = MODE_CENTER; step = 2'd1; end
      {LVL_LO,  LVL_HI }: begin mode_o = MODE_CENTER; step = 2'd2; end
      {LVL_MID, LVL_LO }: begin mode_o = MODE_CENTER; step = 2'd3; end
      {LVL_HI,  LVL_HI }: begin mode_o = MODE_DOWN;   step = 2'd0; end
      {LVL_HI,  LVL_LO }: begin mode_o = MODE_DOWN;   step = 2'd1; end
      {LVL_MID, LVL_HI }: begin mode_o = MODE_DOWN;   step = 2'd2; end
      {LVL_HI,  LVL_MID}: begin mode_o = MODE_DOWN;   step = 2'd3; end
      default:            begin mode_o = MODE_NONE;   step = 2'd0; end
    endcase
    mag_v = MAG_TAB[step] - int'(subband_i);
    if (mag_v < 1) mag_v = 1;
    mag_o = (mode_o == MODE_NONE) ? '0 : MAG_W'(mag_v);
  end
endmodule

// File: rtl/ssc_phase_ctr.sv
module ssc_phase_ctr
  import ssc_pkg::*;
#(
  parameter int PH_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [LOG_W-1:0] lg_i,
  output logic [PH_W-1:0]  phase_o,
  output logic             wrap_o
);
  logic [PH_W-1:0] phase_q;
  logic            last;

  assign last    = (int'(phase_q) == (1 << int'(lg_i)) - 1);
  assign wrap_o  = adv_i & last;
  assign phase_o = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= '0;
    else if (clr_i)  phase_q <= '0;
    else if (adv_i)  phase_q <= last ? '0 : phase_q + 1'b1;
  end

  assert_phase_in_period_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(phase_q) < (1 << int'(lg_i)));
  assert_phase_steps_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !clr_i && !last) |=> (phase_q == $past(phase_q) + 1'b1));
  assert_phase_wraps_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && last) |=> (phase_q == '0));
  assert_phase_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !clr_i) |=> $stable(phase_q));
endmodule

// File: rtl/ssc_profile_calc.sv
module ssc_profile_calc
  import ssc_pkg::*;
#(
  parameter int PH_W   = 9,
  parameter int OFF_W  = 12,
  parameter int FRAC_W = 4
) (
  input  cfg_t                    cfg_i,
  input  logic [PH_W-1:0]         phase_i,
  output logic signed [OFF_W-1:0] offset_o
);
  int half_v, tri_v, sc_v, base_v, mag_v, ph_v;

  always_comb begin
    mag_v  = int'(cfg_i.mag);
    ph_v   = int'(phase_i);
    half_v = 1 << (int'(cfg_i.lg) - 1);
    tri_v  = (ph_v < half_v) ? ph_v : 2 * half_v - ph_v;
    // span is 2*M in both modes; only the floor differs
    sc_v   = ((2 * mag_v * tri_v) <<< FRAC_W) >>> (int'(cfg_i.lg) - 1);
    unique case (cfg_i.mode)
      MODE_CENTER: base_v = -(mag_v <<< FRAC_W);
      MODE_DOWN:   base_v = -((2 * mag_v) <<< FRAC_W);
      default:     begin base_v = 0; sc_v = 0; end
    endcase
    offset_o = OFF_W'(base_v + sc_v);
  end
endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen
  import ssc_pkg::*;
#(
  parameter int DR_LOG2_LO  = 7,
  parameter int DR_LOG2_HI  = 8,
  parameter int DR_LOG2_MID = 9,
  parameter int OFF_W       = 12,
  parameter int FRAC_W      = 4,
  parameter int STEP0_MAG   = 14,
  parameter int STEP1_MAG   = 12,
  parameter int STEP2_MAG   = 6,
  parameter int STEP3_MAG   = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    pd_ni,
  input  logic [1:0]              range_sel_i,
  input  logic [1:0]              spread_a_i,
  input  logic [1:0]              spread_b_i,
  input  logic [1:0]              subband_i,
  output logic signed [OFF_W-1:0] offset_o
);
  localparam int LG_MAX01 = (DR_LOG2_LO > DR_LOG2_HI) ? DR_LOG2_LO : DR_LOG2_HI;
  localparam int PH_W     = (LG_MAX01 > DR_LOG2_MID) ? LG_MAX01 : DR_LOG2_MID;

  logic [5:0] lvl;
  logic [1:0] rng_lvl, a_lvl, b_lvl;
  mode_e      mode_d;
  logic [MAG_W-1:0] mag_d;
  cfg_t       cfg_d, cfg_q;
  logic       loaded_q, running_q, wrap, adv, load;
  logic [PH_W-1:0] phase;
  logic signed [OFF_W-1:0] prof;

  ssc_tri_level_decode #(.N(3)) u_dec (
    .raw_i ({range_sel_i, spread_a_i, spread_b_i}),
    .lvl_o (lvl)
  );
  assign rng_lvl = lvl[5:4];
  assign a_lvl   = lvl[3:2];
  assign b_lvl   = lvl[1:0];

  ssc_spread_lut #(
    .STEP0_MAG(STEP0_MAG), .STEP1_MAG(STEP1_MAG),
    .STEP2_MAG(STEP2_MAG), .STEP3_MAG(STEP3_MAG)
  ) u_lut (
    .sel_a_i   (a_lvl),
    .sel_b_i   (b_lvl),
    .subband_i (subband_i),
    .mode_o    (mode_d),
    .mag_o     (mag_d)
  );

  always_comb begin
    cfg_d.mode = mode_d;
    cfg_d.mag  = mag_d;
    unique case (rng_lvl)
      LVL_LO:  cfg_d.lg = LOG_W'(DR_LOG2_LO);
      LVL_HI:  cfg_d.lg = LOG_W'(DR_LOG2_HI);
      default: cfg_d.lg = LOG_W'(DR_LOG2_MID);
    endcase
  end

  assign adv  = loaded_q & pd_ni;
  assign load = ~loaded_q | wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= '{mode: MODE_NONE, mag: '0, lg: LOG_W'(DR_LOG2_MID)};
      loaded_q  <= 1'b0;
      running_q <= 1'b0;
    end else begin
      if (load) cfg_q <= cfg_d;
      loaded_q  <= 1'b1;
      running_q <= pd_ni;
    end
  end

  ssc_phase_ctr #(.PH_W(PH_W)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (~loaded_q),
    .adv_i   (adv),
    .lg_i    (cfg_q.lg),
    .phase_o (phase),
    .wrap_o  (wrap)
  );

  ssc_profile_calc #(.PH_W(PH_W), .OFF_W(OFF_W), .FRAC_W(FRAC_W)) u_calc (
    .cfg_i    (cfg_q),
    .phase_i  (phase),
    .offset_o (prof)
  );

  assign offset_o = running_q ? prof : '0;

  assert_cfg_only_at_boundary_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loaded_q && !wrap) |=> $stable(cfg_q));
  assert_pd_zero_offset_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_ni |=> (offset_o == '0));
  assert_none_is_flat_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.mode == MODE_NONE) |-> (offset_o == '0));
  assert_offset_upper_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(offset_o) <= (int'(cfg_q.mag) <<< FRAC_W));
  assert_offset_lower_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(offset_o) >= -((2 * int'(cfg_q.mag)) <<< FRAC_W));
  assert_down_not_positive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.mode == MODE_DOWN) |-> (int'(offset_o) <= 0));
  assert_start_at_min_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!loaded_q && pd_ni) |=> (phase == '0));
endmodule

// File: tb/ssc_profile_gen_tb.sv
module ssc_profile_gen_tb;
  localparam int F = 4;
  localparam int OW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_n = 1'b1;
  logic [1:0] rng = 2'b01, sa = 2'b01, sb = 2'b01, sub = 2'b00;
  logic signed [OW-1:0] off;

  always #5 clk = ~clk;

  ssc_profile_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pd_ni(pd_n), .range_sel_i(rng),
    .spread_a_i(sa), .spread_b_i(sb), .subband_i(sub), .offset_o(off)
  );

  typedef struct { int exp; string tag; } item_t;
  item_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  int m_loaded = 0, m_phase = 0, m_run = 0, m_mode = 0, m_mag = 0, m_lg = 9;

  function automatic int lvl(logic [1:0] c);
    return (c == 2'b11) ? 1 : int'(c);
  endfunction

  function automatic void latch_cfg();
    int a, b, step, base[4];
    base = '{14, 12, 6, 5};
    a = lvl(sa); b = lvl(sb);
    m_mode = 0; step = 0;
    if      (a == 0 && b == 0) begin m_mode = 1; step = 0; end
    else if (a == 0 && b == 1) begin m_mode = 1; step = 1; end
    else if (a == 0 && b == 2) begin m_mode = 1; step = 2; end
    else if (a == 1 && b == 0) begin m_mode = 1; step = 3; end
    else if (a == 2 && b == 2) begin m_mode = 2; step = 0; end
    else if (a == 2 && b == 0) begin m_mode = 2; step = 1; end
    else if (a == 1 && b == 2) begin m_mode = 2; step = 2; end
    else if (a == 2 && b == 1) begin m_mode = 2; step = 3; end
    m_mag = base[step] - int'(sub);
    if (m_mag < 1) m_mag = 1;
    case (lvl(rng))
      0: m_lg = 7;
      2: m_lg = 8;
      default: m_lg = 9;
    endcase
  endfunction

  function automatic int model_off();
    int h, t, v;
    if (!m_run || m_mode == 0) return 0;
    h = 1 << (m_lg - 1);
    t = (m_phase < h) ? m_phase : 2 * h - m_phase;
    v = ((2 * m_mag * t) << F) >> (m_lg - 1);
    return (m_mode == 1) ? v - (m_mag << F) : v - ((2 * m_mag) << F);
  endfunction

  task automatic run(input logic p, input logic [1:0] r, a, b, s, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pd_n = p; rng = r; sa = a; sb = b; sub = s;
      if (!m_loaded) begin
        latch_cfg(); m_phase = 0; m_loaded = 1;
      end else if (p) begin
        if (m_phase == (1 << m_lg) - 1) begin m_phase = 0; latch_cfg(); end
        else m_phase++;
      end
      m_run = p;
      q.push_back('{model_off(), tag});
    end
  endtask

  task automatic hold_reset(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rst_n = 1'b0;
      m_loaded = 0; m_phase = 0; m_run = 0; m_mode = 0; m_mag = 0; m_lg = 9;
      q.push_back('{0, "R8"});
    end
    @(negedge clk);
    rst_n = 1'b1;
    m_loaded = 0;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (int'(off) != it.exp) begin
          fails++;
          $display("FAIL %s: offset_o=%0d expected=%0d at %0t", it.tag, off, it.exp, $time);
        end
      end
    end
  end

  // watchdog
  initial begin
    #2000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    hold_reset(4);                                      // R8 reset state
    // the release cycle itself is the load cycle (R8)
    q.push_back('{0, "R8"});
    m_loaded = 1; m_phase = 0; m_run = 1; latch_cfg();  // inputs are mid/mid: no spread
    // R9: no spread for a full 512-cycle period (range middle)
    run(1'b1, 2'b01, 2'b01, 2'b01, 2'b00, 520, "R9");
    // R3/R4/R5: center step 0, sub-band 0; new setting latches at the boundary (R6)
    run(1'b1, 2'b00, 2'b00, 2'b00, 2'b00, 600, "R6");
    // R2: range low, full 128-cycle periods
    run(1'b1, 2'b00, 2'b00, 2'b00, 2'b00, 260, "R2");
    // R4: down spread step 1, sub-band 2, range high, changed mid-period (R6)
    run(1'b1, 2'b10, 2'b10, 2'b00, 2'b10, 600, "R4");
    // R7: power-down mid-sweep, then resume from the held phase
    run(1'b0, 2'b10, 2'b10, 2'b00, 2'b10, 25, "R7");
    run(1'b1, 2'b10, 2'b10, 2'b00, 2'b10, 300, "R7");
    // R1: illegal code 2'b11 read as middle: range mid, (mid,low) center step 3
    run(1'b1, 2'b11, 2'b11, 2'b00, 2'b11, 1100, "R1");
    // R3: down step 2 (mid,high) on range low
    run(1'b1, 2'b00, 2'b01, 2'b10, 2'b01, 800, "R3");
    // R5: center step 2, sub-band 3, range high
    run(1'b1, 2'b10, 2'b00, 2'b10, 2'b11, 600, "R5");
    // R8: reset in mid-run, then restart with down step 3
    hold_reset(3);
    sa = 2'b10; sb = 2'b01; rng = 2'b00; sub = 2'b00;
    m_loaded = 1; m_phase = 0; m_run = 1; latch_cfg();
    q.push_back('{model_off(), "R8"});
    run(1'b1, 2'b00, 2'b10, 2'b01, 2'b00, 300, "R8");
    // R9: (mid,mid) via 2'b11 on both spread selects
    run(1'b1, 2'b00, 2'b11, 2'b11, 2'b00, 300, "R9");
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule